// File: doc/BRIEF.md
# Fixed-to-Floating Point Normalizer

This block turns one wide signed fixed-point sample, for example a real or imaginary part leaving a transform stage, into a compact floating-point word. Later feature arithmetic (energies, ratios, square roots) then works on a short mantissa while keeping the dynamic range of the wide input. Each sample comes with a valid strobe. One clock later the block presents a 24-bit word: an 18-bit two's-complement mantissa and a 6-bit unsigned exponent.

The block strips the redundant copies of the sign bit. It searches for the highest bit that differs from the sign, below the sign bit itself. That search runs in fixed-width segments in parallel, and a short priority stage merges their results. The exponent is the number of places the sample has to be shifted right so that it fits the signed mantissa. The value represented is mantissa × 2^exponent. Samples that already fit pass unshifted with exponent zero. Bits that are shifted out are dropped, so the result is truncated toward negative infinity.

Top module: `fxfl_normalizer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_vld` is 0 and `out_word` is all zeros.
- R2: `out_vld` in a cycle equals `in_vld` sampled at the previous rising clock edge.
- R3: An input whose bits 37 down to 17 are all equal is passed with exponent 0 and mantissa equal to its low 18 bits.
- R4: An all-zero input gives mantissa 0 and exponent 0. An all-ones input gives mantissa −1 (all 18 bits set) and exponent 0.
- R5: The exponent is the smallest shift count e for which the input arithmetically shifted right by e lies in [−2^17, 2^17−1]. When e > 0, mantissa bit 16 differs from mantissa bit 17.
- R6: The mantissa equals floor(input / 2^exponent), which is truncation toward negative infinity.
- R7: Full scale maps to exponent 20. Input −2^37 gives mantissa −2^17, and input 2^37−1 gives mantissa 2^17−1.
- R8: The exponent never exceeds 20.
- R9: In a cycle with `in_vld` low, `in_data` is ignored and `out_word` keeps its previous value.
- R10: `out_word` carries the mantissa in bits 23:6 and the exponent in bits 5:0. For example, input 1 yields 24'h000040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample strobe |
| in_data | input | 38 | Signed two's-complement fixed-point sample |
| out_vld | output | 1 | Output word strobe, one clock after `in_vld` |
| out_word | output | 24 | Mantissa in bits 23:6, exponent in bits 5:0 |

## Verification
The bench builds the block with its default widths: a 38-bit input, 18/6 output fields, 8-bit search segments and the segmented search variant. With a 37-bit difference vector, the top segment is only five bits wide and padded. Inputs are spread across every leading-bit position, so each segment and each exponent from 0 to 20 is reached. The bench also applies both full-scale extremes, negative samples with non-zero dropped bits, and idle cycles that carry garbage data. Because the segment width is a parameter, the merge stage is exercised across a partly empty top segment.

// File: rtl/fxfl_pkg.sv
package fxfl_pkg;
   localparam int unsigned IN_W_DEF  = 38;
   localparam int unsigned MAN_W_DEF = 18;
   localparam int unsigned EXP_W_DEF = 6;
   localparam int unsigned SEG_W_DEF = 8;

   typedef enum logic {
      SEARCH_FLAT      = 1'b0,
      SEARCH_SEGMENTED = 1'b1
   } search_e;
endpackage

// File: rtl/fxfl_seg_detect.sv
module fxfl_seg_detect #(
   parameter int unsigned SEG_W = 8,
   localparam int unsigned IDX_W = (SEG_W > 1) ? $clog2(SEG_W) : 1
) (
   input  logic [SEG_W-1:0] seg_bits,
   output logic             seg_hit,
   output logic [IDX_W-1:0] seg_idx
);
   always_comb begin
      seg_hit = |seg_bits;
      seg_idx = '0;
      for (int i = 0; i < int'(SEG_W); i++) begin
         if (seg_bits[i]) seg_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/fxfl_lead_find.sv
module fxfl_lead_find #(
   parameter int unsigned DW    = 37,
   parameter int unsigned SEG_W = 8,
   parameter fxfl_pkg::search_e SEARCH = fxfl_pkg::SEARCH_SEGMENTED,
   localparam int unsigned POS_W = $clog2(DW + 1)
) (
   input  logic [DW-1:0]    diff,
   output logic             found,
   output logic [POS_W-1:0] pos
);
   localparam int unsigned NSEG  = (DW + SEG_W - 1) / SEG_W;
   localparam int unsigned PAD_W = NSEG * SEG_W;
   localparam int unsigned IDX_W = (SEG_W > 1) ? $clog2(SEG_W) : 1;

   if (SEARCH == fxfl_pkg::SEARCH_SEGMENTED) begin : g_seg
      logic [PAD_W-1:0] padded;
      logic [NSEG-1:0]  hit;
      logic [IDX_W-1:0] idx [NSEG];

      assign padded = PAD_W'(diff);

      for (genvar s = 0; s < int'(NSEG); s++) begin : g_unit
         fxfl_seg_detect #(.SEG_W(SEG_W)) u_det (
            .seg_bits (padded[s*SEG_W +: SEG_W]),
            .seg_hit  (hit[s]),
            .seg_idx  (idx[s])
         );
      end

      always_comb begin
         found = |hit;
         pos   = '0;
         for (int s = 0; s < int'(NSEG); s++) begin
            if (hit[s]) pos = POS_W'(s * int'(SEG_W)) + POS_W'(idx[s]);
         end
      end
   end else begin : g_flat
      always_comb begin
         found = |diff;
         pos   = '0;
         for (int i = 0; i < int'(DW); i++) begin
            if (diff[i]) pos = POS_W'(i);
         end
      end
   end
endmodule

// File: rtl/fxfl_rshift.sv
module fxfl_rshift #(
   parameter int unsigned IN_W  = 38,
   parameter int unsigned MAN_W = 18,
   parameter int unsigned SH_W  = 5
) (
   input  logic [IN_W-1:0]  din,
   input  logic [SH_W-1:0]  sh,
   output logic [MAN_W-1:0] mant
);
   logic [IN_W-1:0] stage [SH_W+1];

   assign stage[0] = din;

   for (genvar k = 0; k < int'(SH_W); k++) begin : g_stage
      assign stage[k+1] = sh[k] ? IN_W'($signed(stage[k]) >>> (1 << k)) : stage[k];
   end

   assign mant = stage[SH_W][MAN_W-1:0];
endmodule

// File: rtl/fxfl_normalizer.sv
module fxfl_normalizer #(
   parameter int unsigned IN_W  = fxfl_pkg::IN_W_DEF,
   parameter int unsigned MAN_W = fxfl_pkg::MAN_W_DEF,
   parameter int unsigned EXP_W = fxfl_pkg::EXP_W_DEF,
   parameter int unsigned SEG_W = fxfl_pkg::SEG_W_DEF,
   parameter fxfl_pkg::search_e SEARCH = fxfl_pkg::SEARCH_SEGMENTED
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_vld,
   input  logic [IN_W-1:0]        in_data,
   output logic                   out_vld,
   output logic [MAN_W+EXP_W-1:0] out_word
);
   localparam int unsigned DW        = IN_W - 1;
   localparam int unsigned POS_W     = $clog2(DW + 1);
   localparam int unsigned SHIFT_MAX = IN_W - MAN_W;
   localparam int unsigned SH_W      = $clog2(SHIFT_MAX + 1);
   localparam int unsigned TOP_POS   = MAN_W - 2;

   if (MAN_W < 2 || MAN_W >= IN_W) begin : g_bad_man
      $error("mantissa width must lie in [2, input width)");
   end
   if (SHIFT_MAX >= (1 << EXP_W)) begin : g_bad_exp
      $error("exponent field too narrow for the largest shift");
   end
   if (SEG_W < 2 || (SEG_W & (SEG_W - 1)) != 0) begin : g_bad_seg
      $error("segment width must be a power of two, at least 2");
   end

   logic [DW-1:0]    diff;
   logic             found;
   logic [POS_W-1:0] pos;
   logic [SH_W-1:0]  shamt;
   logic [MAN_W-1:0] mant;

   assign diff = in_data[DW-1:0] ^ {DW{in_data[IN_W-1]}};

   fxfl_lead_find #(.DW(DW), .SEG_W(SEG_W), .SEARCH(SEARCH)) u_find (
      .diff  (diff),
      .found (found),
      .pos   (pos)
   );

   always_comb begin
      if (found && (pos > POS_W'(TOP_POS))) shamt = SH_W'(pos - POS_W'(TOP_POS));
      else                                  shamt = '0;
   end

   fxfl_rshift #(.IN_W(IN_W), .MAN_W(MAN_W), .SH_W(SH_W)) u_shift (
      .din  (in_data),
      .sh   (shamt),
      .mant (mant)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_word <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_word <= {mant, EXP_W'(shamt)};
      end
   end
endmodule

// File: rtl/fxfl_normalizer_chk.sv
module fxfl_normalizer_chk #(
   parameter int unsigned IN_W  = 38,
   parameter int unsigned MAN_W = 18,
   parameter int unsigned EXP_W = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_vld,
   input logic [IN_W-1:0]        in_data,
   input logic                   out_vld,
   input logic [MAN_W+EXP_W-1:0] out_word
);
   localparam int unsigned SHIFT_MAX = IN_W - MAN_W;

   logic [MAN_W-1:0]  c_mant;
   logic [EXP_W-1:0]  c_exp;
   logic signed [63:0] prev_x, lo, hi;
   logic              fits;

   assign c_mant = out_word[MAN_W+EXP_W-1:EXP_W];
   assign c_exp  = out_word[EXP_W-1:0];
   assign fits   = (&in_data[IN_W-1:MAN_W-1]) || !(|in_data[IN_W-1:MAN_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_x <= '0;
      else if (in_vld) prev_x <= 64'($signed(in_data));
   end

   always_comb begin
      lo = 64'($signed(c_mant)) <<< c_exp;
      hi = (64'($signed(c_mant)) + 64'sd1) <<< c_exp;
   end

   // R2
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);
   // R2
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld);
   // R9
   hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(out_word));
   // R8
   exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (c_exp <= EXP_W'(SHIFT_MAX)));
   // R5
   normalized_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && c_exp != '0) |-> (c_mant[MAN_W-1] != c_mant[MAN_W-2]));
   // R3
   no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && fits) |=> (c_exp == '0));
   // R6
   floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (prev_x >= lo && prev_x < hi));
endmodule

bind fxfl_normalizer fxfl_normalizer_chk #(.IN_W(IN_W), .MAN_W(MAN_W), .EXP_W(EXP_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_vld   (in_vld),
   .in_data  (in_data),
   .out_vld  (out_vld),
   .out_word (out_word)
);

// File: tb/fxfl_normalizer_bench.sv
module fxfl_normalizer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [37:0] in_data = '0;
   logic        out_vld;
   logic [23:0] out_word;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic        exp_vld  = 1'b0;
   logic [23:0] exp_word = '0;

   always #4 clk = ~clk;

   fxfl_normalizer u_fxfl_normalizer (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (in_vld),
      .in_data  (in_data),
      .out_vld  (out_vld),
      .out_word (out_word)
   );

   function automatic logic [23:0] ref_word(input logic [37:0] d);
      longint x = longint'($signed(d));
      for (int e = 0; e <= 20; e++) begin
         longint m = x >>> e;
         if (m >= -131072 && m <= 131071) return {m[17:0], 6'(e)};
      end
      return 24'hFFFFFF;
   endfunction

   task automatic check(input string tag);
      checks++;
      if (out_vld !== exp_vld || out_word !== exp_word) begin
         fails++;
         $display("FAIL %s: vld=%0b word=%h expected vld=%0b word=%h",
                  tag, out_vld, out_word, exp_vld, exp_word);
      end
   endtask

   task automatic step(input logic v, input logic [37:0] d, input string tag);
      in_vld  = v;
      in_data = d;
      @(posedge clk);
      exp_vld = v;
      if (v) exp_word = ref_word(d);
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");

      // R10: field layout, input 1 -> 24'h000040
      step(1'b1, 38'd1, "R10");
      checks++;
      if (out_word !== 24'h000040) begin
         fails++;
         $display("FAIL R10: word=%h expected word=%h", out_word, 24'h000040);
      end

      // R3: values that already fit
      step(1'b1, 38'd12345, "R3");
      step(1'b1, 38'd131071, "R3");
      step(1'b1, -38'sd131072, "R3");
      step(1'b1, -38'sd777, "R3");

      // R4: all zeros / all ones
      step(1'b1, '0, "R4");
      step(1'b1, '1, "R4");

      // R5: just beyond mantissa range
      step(1'b1, 38'd131072, "R5");
      step(1'b1, -38'sd131073, "R5");
      step(1'b1, 38'h0040000005, "R5");

      // R6: negative with dropped ones
      step(1'b1, -38'sd33554429, "R6");
      step(1'b1, -38'sd1000000001, "R6");

      // R7: full scale
      step(1'b1, 38'h2000000000, "R7");
      step(1'b1, 38'h1FFFFFFFFF, "R7");

      // R9: idle cycles with garbage data
      step(1'b0, 38'h15A5A5A5A5, "R9");
      step(1'b0, 38'h0123456789, "R9");
      step(1'b0, '1, "R9");

      // R2: alternating strobe
      for (int i = 0; i < 8; i++) step(i[0], 38'(i * 9973 + 1), "R2");

      // R5/R6/R8: sweep of every magnitude
      for (int i = 0; i < 3000; i++) begin
         longint r = longint'($signed({6'($urandom), $urandom}));
         r = r >>> ($urandom % 38);
         step(($urandom % 4) != 0, r[37:0], "R5/R6/R8");
      end

      step(1'b0, '0, "R2");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R2: watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule